// File: doc/BRIEF.md
# Flash Page Buffer and Erase/Write Sequencer

This block sits between a processor's self-programming path and a behavioural model of a word-organised flash array. Software fills a temporary page buffer one 16-bit word at a time, at any position and in any order. It then starts a page erase and a page write, each aimed at a page through a 16-bit byte pointer. The upper pointer bits pick the page and the lower bits pick the word inside it. Each operation captures its page address when it is accepted, holds a busy flag for a fixed, parameterised number of cycles, and then signals completion with a one-cycle pulse. The busy cycles stand in for real cell timing.

Program-memory reads address bytes, so pointer bit 0 chooses between the two halves of a word. A re-enable command throws away whatever the buffer holds. A lock-set command programs two protection bits. One of them guards the pages below a boundary page, which is given as a parameter. The other guards the pages at and above that boundary. Lock bits can only be cleared, and only a reset brings them back. A write does not erase the page first: it can only clear bits, so a page must be erased before new data can be written to it reliably.

Top module: `flash_page_seq`

## Requirements
- R1: With the default sizes (1024 words, 32 words per page), load, erase and write take the word-in-page index from ptr[5:1] and the page from ptr[10:6]. ptr[0] and ptr[15:11] are ignored.
- R2: When rd_en is high at a clock edge, rd_data holds a byte after that edge. It is the high byte of word ptr[10:1] when ptr[0]=1 and the low byte when ptr[0]=0.
- R3: A load command (cmd_op=0) stores wdata at the addressed buffer position. Positions may be loaded in any order, and later loads leave other positions untouched.
- R4: An erase (cmd_op=1) sets every word of the page to 16'hFFFF. A write (cmd_op=2) replaces each page word with its bitwise AND with the matching buffer word, then returns the whole buffer to all ones.
- R5: Erase and write latch their page when accepted. Later changes to ptr do not change which page is affected.
- R6: An accepted erase or write holds busy high for exactly BUSY_CYCLES cycles (default 4). done is then high for exactly one cycle, starting as busy falls.
- R7: Every command issued while busy is high is ignored and does not extend or restart the operation.
- R8: The buffer may be filled either before the erase or between the erase and the write; both orders give the same page contents.
- R9: A re-enable command (cmd_op=3) returns every buffer word to 16'hFFFF, which discards any loaded data.
- R10: A lock-set command (cmd_op=4) ANDs wdata[1:0] into lock_bits and ignores ptr. A lock bit never returns from 0 to 1 except through reset. Codes 5 to 7 are ignored.
- R11: When lock_bits[0]=0, erase and write aimed at pages below BOOT_START_PAGE (default 24) are ignored. When lock_bits[1]=0, erase and write aimed at pages at or above it are ignored. A blocked command raises no busy and changes no page.
- R12: After reset, busy=0, done=0, rd_data=0 and lock_bits=2'b11, and both the array and the buffer read as all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, sampled each clock |
| cmd_op | input | 3 | Command code: 0 load, 1 erase, 2 write, 3 re-enable, 4 lock-set |
| ptr | input | 16 | Byte pointer for commands and reads |
| wdata | input | 16 | Load data word; bits 1:0 also carry the lock-set value |
| rd_en | input | 1 | Read request for the byte at ptr |
| rd_data | output | 8 | Byte returned one cycle after rd_en |
| busy | output | 1 | Erase or write in progress |
| done | output | 1 | One-cycle completion pulse |
| lock_bits | output | 2 | Protection bits, 0 = protected |

## Verification
A wrong latched page shows up in the next byte read after done: one page keeps stale data and another page changes unexpectedly. A buffer that is not reset after a write or a re-enable shows up one write later, when bits are cleared that should have stayed set. An off-by-one in the busy counter is visible at the ports in the same operation, as a busy window of the wrong length or a done pulse at the wrong time. Errors in the lock decode appear at once as a busy flag that rises when it should stay low, or stays low when it should rise.

// File: rtl/flash_page_seq.sv
module flash_page_seq #(
  parameter int PTR_W           = 16,
  parameter int FLASH_WORDS     = 1024,
  parameter int PAGE_WORDS      = 32,
  parameter int BOOT_START_PAGE = 24,
  parameter int BUSY_CYCLES     = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_op,
  input  logic [15:0] ptr,
  input  logic [15:0] wdata,
  input  logic        rd_en,
  output logic [7:0]  rd_data,
  output logic        busy,
  output logic        done,
  output logic [1:0]  lock_bits
);
  localparam int WORD_AW = $clog2(FLASH_WORDS);
  localparam int OFS_W   = $clog2(PAGE_WORDS);
  localparam int PAGE_W  = WORD_AW - OFS_W;
  localparam int CNT_W   = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0]  CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);
  localparam logic [PAGE_W-1:0] BOOT_PG  = PAGE_W'(BOOT_START_PAGE);

  localparam logic [2:0] OP_LOAD  = 3'd0;
  localparam logic [2:0] OP_ERASE = 3'd1;
  localparam logic [2:0] OP_WRITE = 3'd2;
  localparam logic [2:0] OP_REEN  = 3'd3;
  localparam logic [2:0] OP_LOCK  = 3'd4;

  logic [15:0]       mem  [FLASH_WORDS];
  logic [15:0]       pbuf [PAGE_WORDS];
  logic [CNT_W-1:0]  cnt;
  logic [PAGE_W-1:0] op_page;
  logic              op_is_write;

  wire [OFS_W-1:0]   ptr_ofs  = ptr[OFS_W:1];
  wire [PAGE_W-1:0]  ptr_page = ptr[WORD_AW:OFS_W+1];
  wire [WORD_AW-1:0] ptr_word = ptr[WORD_AW:1];
  wire [15:0]        rd_word  = mem[ptr_word];
  wire               unused_ptr_hi = ^ptr[PTR_W-1:WORD_AW+1];

  wire page_locked = (ptr_page < BOOT_PG) ? !lock_bits[0] : !lock_bits[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      done        <= 1'b0;
      rd_data     <= '0;
      lock_bits   <= 2'b11;
      cnt         <= '0;
      op_page     <= '0;
      op_is_write <= 1'b0;
      for (int i = 0; i < FLASH_WORDS; i++) mem[i] <= '1;
      for (int i = 0; i < PAGE_WORDS; i++) pbuf[i] <= '1;
    end else begin
      done <= 1'b0;
      if (rd_en) rd_data <= ptr[0] ? rd_word[15:8] : rd_word[7:0];
      if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
          for (int i = 0; i < PAGE_WORDS; i++) begin
            if (op_is_write) begin
              mem[{op_page, i[OFS_W-1:0]}] <= mem[{op_page, i[OFS_W-1:0]}] & pbuf[i];
              pbuf[i] <= '1;
            end else begin
              mem[{op_page, i[OFS_W-1:0]}] <= '1;
            end
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (cmd_valid) begin
        case (cmd_op)
          OP_LOAD: pbuf[ptr_ofs] <= wdata;
          OP_ERASE, OP_WRITE: begin
            if (!page_locked) begin
              busy        <= 1'b1;
              cnt         <= CNT_LOAD;
              op_page     <= ptr_page;
              op_is_write <= (cmd_op == OP_WRITE);
            end
          end
          OP_REEN: for (int i = 0; i < PAGE_WORDS; i++) pbuf[i] <= '1;
          OP_LOCK: lock_bits <= lock_bits & wdata[1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_page_seq_chk.sv
module flash_page_seq_chk #(
  parameter int BUSY_CYCLES = 4,
  parameter int PAGE_W      = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [1:0]        lock_bits,
  input logic [PAGE_W-1:0] op_page
);
  int run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && $past(busy))); // R6
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> run_len == BUSY_CYCLES); // R6
  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(op_page)); // R5
  AST_LOCK_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (lock_bits & ~$past(lock_bits)) == 2'b00); // R10
endmodule

bind flash_page_seq flash_page_seq_chk #(.BUSY_CYCLES(BUSY_CYCLES), .PAGE_W(PAGE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .lock_bits(lock_bits), .op_page(op_page)
);

// File: tb/flash_page_seq_tb.sv
module flash_page_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY_CYCLES = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [15:0] ptr = '0;
  logic [15:0] wdata = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic        busy, done;
  logic [1:0]  lock_bits;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_page_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .ptr(ptr),
    .wdata(wdata), .rd_en(rd_en), .rd_data(rd_data), .busy(busy), .done(done),
    .lock_bits(lock_bits)
  );

  function automatic logic [15:0] mkptr(input int page, input int ofs, input bit b0);
    return 16'(page * 64 + ofs * 2 + int'(b0));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input logic [15:0] p, input logic [15:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; ptr = p; wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic run_op(input logic [2:0] op, input logic [15:0] p, input logic [15:0] new_ptr);
    int n;
    cmd(op, p, 16'h0);
    ptr = new_ptr;
    n = 0;
    while (busy && n < 100) begin n++; @(negedge clk); end
    chk(n == BUSY_CYCLES, "R6 busy length", n, BUSY_CYCLES);
    chk(done == 1'b1, "R6 done at busy fall", done, 1);
    @(negedge clk);
    chk(done == 1'b0, "R6 done one cycle", done, 0);
  endtask

  task automatic rdw(input int page, input int ofs, output logic [15:0] w);
    @(negedge clk); rd_en = 1'b1; ptr = mkptr(page, ofs, 1'b0);
    @(negedge clk); w[7:0] = rd_data; ptr = mkptr(page, ofs, 1'b1);
    @(negedge clk); w[15:8] = rd_data; rd_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] w;
    chk(busy == 1'b0, "R12 busy", busy, 0);
    chk(done == 1'b0, "R12 done", done, 0);
    chk(rd_data == 8'h00, "R12 rd_data", rd_data, 0);
    chk(lock_bits == 2'b11, "R12 lock_bits", lock_bits, 2'b11);
    rdw(9, 3, w);
    chk(w == 16'hFFFF, "R12 array ones", w, 16'hFFFF);
  endtask

  task automatic t_fill_after_erase;
    logic [15:0] w;
    run_op(3'd1, mkptr(2, 0, 1'b1) | 16'hF800, 16'h0);
    cmd(3'd0, mkptr(2, 31, 1'b1) | 16'hA000, 16'h1F1F);
    cmd(3'd0, mkptr(2, 5, 1'b0), 16'h5A3C);
    cmd(3'd0, mkptr(2, 0, 1'b1), 16'h0102);
    run_op(3'd2, mkptr(2, 7, 1'b0), 16'h0);
    rdw(2, 5, w);  chk(w == 16'h5A3C, "R3 R8 word5", w, 16'h5A3C);
    rdw(2, 0, w);  chk(w == 16'h0102, "R1 word0 ptr0 ignored", w, 16'h0102);
    rdw(2, 31, w); chk(w == 16'h1F1F, "R1 word31 upper ignored", w, 16'h1F1F);
    rdw(2, 7, w);  chk(w == 16'hFFFF, "R4 unloaded word", w, 16'hFFFF);
    @(negedge clk); rd_en = 1'b1; ptr = mkptr(2, 5, 1'b1);
    @(negedge clk); rd_en = 1'b0;
    chk(rd_data == 8'h5A, "R2 high byte", rd_data, 8'h5A);
    @(negedge clk); rd_en = 1'b1; ptr = mkptr(2, 5, 1'b0);
    @(negedge clk); rd_en = 1'b0;
    chk(rd_data == 8'h3C, "R2 low byte", rd_data, 8'h3C);
  endtask

  task automatic t_fill_before_erase;
    logic [15:0] w;
    cmd(3'd0, mkptr(3, 12, 1'b0), 16'hC0DE);
    run_op(3'd1, mkptr(3, 0, 1'b0), 16'h0);
    run_op(3'd2, mkptr(3, 0, 1'b0), 16'h0);
    rdw(3, 12, w); chk(w == 16'hC0DE, "R8 load before erase", w, 16'hC0DE);
    run_op(3'd2, mkptr(3, 0, 1'b0), 16'h0);
    rdw(3, 12, w); chk(w == 16'hC0DE, "R4 buffer ones after write", w, 16'hC0DE);
  endtask

  task automatic t_and_write;
    logic [15:0] w;
    cmd(3'd0, mkptr(4, 1, 1'b0), 16'hA5A5);
    run_op(3'd2, mkptr(4, 1, 1'b0), 16'h0);
    cmd(3'd0, mkptr(4, 1, 1'b0), 16'h0F0F);
    run_op(3'd2, mkptr(4, 1, 1'b0), 16'h0);
    rdw(4, 1, w); chk(w == 16'h0505, "R4 AND write", w, 16'h0505);
  endtask

  task automatic t_latch;
    logic [15:0] w;
    cmd(3'd0, mkptr(5, 2, 1'b0), 16'h1234);
    run_op(3'd2, mkptr(5, 2, 1'b0), mkptr(6, 2, 1'b0));
    rdw(5, 2, w); chk(w == 16'h1234, "R5 latched page", w, 16'h1234);
    rdw(6, 2, w); chk(w == 16'hFFFF, "R5 other page", w, 16'hFFFF);
  endtask

  task automatic t_busy_ignore;
    logic [15:0] w;
    int n;
    cmd(3'd1, mkptr(2, 0, 1'b0), 16'h0);
    cmd(3'd0, mkptr(2, 5, 1'b0), 16'h0000);
    cmd(3'd2, mkptr(2, 0, 1'b0), 16'h0);
    n = 0;
    while (busy && n < 100) begin n++; @(negedge clk); end
    @(negedge clk);
    chk(busy == 1'b0, "R7 no restart", busy, 0);
    rdw(2, 5, w); chk(w == 16'hFFFF, "R7 erase done only", w, 16'hFFFF);
    run_op(3'd2, mkptr(2, 0, 1'b0), 16'h0);
    rdw(2, 5, w); chk(w == 16'hFFFF, "R7 load ignored", w, 16'hFFFF);
  endtask

  task automatic t_reenable;
    logic [15:0] w;
    cmd(3'd0, mkptr(7, 9, 1'b0), 16'h0000);
    cmd(3'd3, 16'h0, 16'h0);
    run_op(3'd2, mkptr(7, 0, 1'b0), 16'h0);
    rdw(7, 9, w); chk(w == 16'hFFFF, "R9 buffer discarded", w, 16'hFFFF);
  endtask

  task automatic t_lock;
    logic [15:0] w;
    cmd(3'd4, 16'hBEEF, 16'hFFFE);
    chk(lock_bits == 2'b10, "R10 lockset", lock_bits, 2'b10);
    cmd(3'd5, 16'h0, 16'h0000);
    chk(lock_bits == 2'b10, "R10 unused code", lock_bits, 2'b10);
    cmd(3'd1, mkptr(4, 0, 1'b0), 16'h0);
    chk(busy == 1'b0, "R11 app erase blocked", busy, 0);
    rdw(4, 1, w); chk(w == 16'h0505, "R11 app page kept", w, 16'h0505);
    cmd(3'd4, 16'h1234, 16'h0003);
    chk(lock_bits == 2'b10, "R10 no set back", lock_bits, 2'b10);
    cmd(3'd0, mkptr(30, 4, 1'b0), 16'h7777);
    run_op(3'd2, mkptr(30, 0, 1'b0), 16'h0);
    rdw(30, 4, w); chk(w == 16'h7777, "R11 boot write allowed", w, 16'h7777);
    cmd(3'd4, 16'h0000, 16'h0001);
    chk(lock_bits == 2'b00, "R10 second bit", lock_bits, 2'b00);
    cmd(3'd1, mkptr(24, 0, 1'b0), 16'h0);
    chk(busy == 1'b0, "R11 boot erase blocked", busy, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_fill_after_erase;
    t_fill_before_erase;
    t_and_write;
    t_latch;
    t_busy_ignore;
    t_reenable;
    t_lock;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule